// File: doc/BRIEF.md
# PCIe Fundamental Reset Sequencing Guard

This block sits between a raw board-level reset source and the single active-low fundamental reset pin of a multi-port PCIe hard block. It takes a power-good level, a host reset request, one stable flag per reference clock and one FLR-received flag per physical function. From these it produces a cleaned reset output. Every asynchronous input first passes through a two-flop synchronizer. The output is driven from a register.

The guard holds the output asserted until the last reference clock reports stable. After every release it keeps the output high for a minimum gap. It refuses to start a host-requested reset while any function has an FLR in progress, and for a settling window after all of them finish. A host request that arrives inside one of these windows is remembered and carried out when the window ends. A loss of power-good always forces the output low at once. If that happens inside a protected window, a sticky violation flag records it.

The output reaches every port of the hard block together. Ports that have been split cannot be reset one at a time through this pin. Windows are given in microseconds and converted to clock cycles through `CYCLES_PER_US`. All pins are plain control and status levels, so the block has no valid/ready handshake and no back-pressure.

Top module: `pcie_rst_guard`

## Requirements
- R1: While `rst_n` is low, and just after it, the outputs are `fund_rst_n`=0, `req_deferred`=0, `seq_violation`=0 and `seq_state`=0 (holding reset).
- R2: `fund_rst_n` rises only once all `NUM_CLK` synchronized clock-stable flags are high. If one clock becomes stable after the others, release follows that last flag by three cycles: two synchronizer stages plus the state register.
- R3: While any synchronized FLR flag is high, a host request causes no assertion. The output stays high, and the block waits in state 4.
- R4: A host-requested assertion waits until the synchronized OR of the FLR flags has been low for `FLR_US*CYCLES_PER_US` consecutive cycles. When the request is already waiting, the output falls three cycles after the settling window completes, counted from the FLR input going low, plus the window itself.
- R5: After each release the output stays high for at least `GAP_US*CYCLES_PER_US` cycles before any host-requested assertion. Because of this, two assertions are never closer than that gap. During the gap the state is 3. Once the gap runs out and nothing is pending, the state becomes 2.
- R6: A host request seen inside the minimum gap or the FLR window is not dropped. `req_deferred` goes high within three cycles and stays high after the request input falls. The reset is applied when the window ends, and `req_deferred` clears at that point.
- R7: A loss of power-good forces `fund_rst_n` low within three cycles in every state. If this happens in state 3, in state 4, or in state 2 while FLR settling is not complete, `seq_violation` is set and stays set until `rst_n`.
- R8: A loss of power-good in state 2 after FLR settling has completed does not set `seq_violation`.
- R9: The output stays low while the host request is held. Once the request drops, with all clocks stable, the block passes through state 1 and releases one cycle later.
- R10: `seq_state` encodes 0=holding reset, 1=waiting for clocks, 2=released, 3=minimum gap, 4=FLR holdoff. `fund_rst_n` is high exactly in states 2, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all logic and window counting |
| rst_n | input | 1 | Active-low asynchronous reset of the guard itself |
| pwr_good_raw | input | 1 | Asynchronous power-good level; low forces reset |
| host_rst_req_raw | input | 1 | Asynchronous host reset request, active high |
| refclk_ok_raw | input | NUM_CLK | Asynchronous stable flag per reference clock |
| flr_pend_raw | input | NUM_PF | Asynchronous FLR-received flag per physical function |
| fund_rst_n | output | 1 | Conditioned active-low fundamental reset, registered |
| seq_state | output | 3 | Sequencer state code (see R10) |
| req_deferred | output | 1 | A host request is held pending behind a window |
| seq_violation | output | 1 | Sticky: power-good lost inside a protected window |

## Verification
The bench builds the guard with `CYCLES_PER_US`=2, `GAP_US`=5 and `FLR_US`=7. The gap is then 10 cycles and the FLR settling window 14 cycles. At that scale a request can be deferred behind the gap and then released within a few dozen cycles, and the same holds for the FLR window. Short settings like these let the random phase place several hundred requests, FLR pulses, power-good drops and clock dropouts in a short run. The directed cases can then probe the exact cycle on which each window ends.

// File: rtl/prg_pkg.sv
package prg_pkg;

  typedef enum logic [2:0] {
    ST_ASSERTED    = 3'd0,
    ST_WAIT_CLKS   = 3'd1,
    ST_RELEASED    = 3'd2,
    ST_MIN_GAP     = 3'd3,
    ST_FLR_HOLDOFF = 3'd4
  } seq_state_e;

  // States in which the conditioned reset output is deasserted (high).
  function automatic logic state_out_high(seq_state_e s);
    return (s == ST_RELEASED) || (s == ST_MIN_GAP) || (s == ST_FLR_HOLDOFF);
  endfunction

endpackage

// File: rtl/prg_sync.sv
module prg_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/prg_flr_monitor.sv
module prg_flr_monitor #(
  parameter int NUM_PF    = 4,
  parameter int QUIET_CYC = 28000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PF-1:0] flr_sync,
  output logic              flr_busy,
  output logic              flr_settled
);

  localparam int CW = $clog2(QUIET_CYC + 1);
  localparam logic [CW-1:0] QUIET_MAX = CW'(QUIET_CYC);

  logic [CW-1:0] quiet_cnt;

  assign flr_busy    = |flr_sync;
  assign flr_settled = (quiet_cnt == QUIET_MAX);

  // Counts consecutive cycles with no FLR in flight, saturating at the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           quiet_cnt <= '0;
    else if (flr_busy)    quiet_cnt <= '0;
    else if (!flr_settled) quiet_cnt <= quiet_cnt + 1'b1;
  end

endmodule

// File: rtl/prg_gap_timer.sv
module prg_gap_timer #(
  parameter int GAP_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);

  localparam int CW = $clog2(GAP_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(GAP_CYC - 1);

  logic [CW-1:0] cnt;

  assign done = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (start)         cnt <= '0;
    else if (run && !done)  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/pcie_rst_guard.sv
module pcie_rst_guard
  import prg_pkg::*;
#(
  parameter int NUM_PF        = 4,
  parameter int NUM_CLK       = 4,
  parameter int CYCLES_PER_US = 100,
  parameter int GAP_US        = 50,
  parameter int FLR_US        = 280
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good_raw,
  input  logic               host_rst_req_raw,
  input  logic [NUM_CLK-1:0] refclk_ok_raw,
  input  logic [NUM_PF-1:0]  flr_pend_raw,
  output logic               fund_rst_n,
  output logic [2:0]         seq_state,
  output logic               req_deferred,
  output logic               seq_violation
);

  localparam int GAP_CYC = GAP_US * CYCLES_PER_US;
  localparam int FLR_CYC = FLR_US * CYCLES_PER_US;

  // ---------------- input synchronizers ----------------
  logic [1:0]         ctl_s;
  logic               pg_s, req_s;
  logic [NUM_CLK-1:0] clk_s;
  logic [NUM_PF-1:0]  flr_s;
  logic               clk_ok;

  prg_sync #(.WIDTH(2)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d({pwr_good_raw, host_rst_req_raw}), .q(ctl_s));
  prg_sync #(.WIDTH(NUM_CLK)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d(refclk_ok_raw), .q(clk_s));
  prg_sync #(.WIDTH(NUM_PF)) u_sync_flr (
    .clk(clk), .rst_n(rst_n), .d(flr_pend_raw), .q(flr_s));

  assign pg_s   = ctl_s[1];
  assign req_s  = ctl_s[0];
  assign clk_ok = &clk_s;

  // ---------------- FLR settling and gap timing ----------------
  logic flr_busy, flr_settled, flr_clear;
  logic gap_start, gap_done;

  seq_state_e state_q, state_n;
  logic       pend_q, pend_n;
  logic       viol_q, viol_n;
  logic       out_q;

  prg_flr_monitor #(.NUM_PF(NUM_PF), .QUIET_CYC(FLR_CYC)) u_flr (
    .clk(clk), .rst_n(rst_n), .flr_sync(flr_s),
    .flr_busy(flr_busy), .flr_settled(flr_settled));

  prg_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start),
    .run(state_q == ST_MIN_GAP), .done(gap_done));

  assign flr_clear = flr_settled && !flr_busy;

  // ---------------- sequencer ----------------
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_ASSERTED: begin
        if (pg_s && !req_s) state_n = ST_WAIT_CLKS;
      end
      ST_WAIT_CLKS: begin
        if (!pg_s || req_s) state_n = ST_ASSERTED;
        else if (clk_ok)    state_n = ST_MIN_GAP;
      end
      ST_MIN_GAP: begin
        if (!pg_s) state_n = ST_ASSERTED;
        else if (gap_done) begin
          if (pend_q || req_s) state_n = flr_clear ? ST_ASSERTED : ST_FLR_HOLDOFF;
          else                 state_n = ST_RELEASED;
        end
      end
      ST_RELEASED: begin
        if (!pg_s)      state_n = ST_ASSERTED;
        else if (req_s) state_n = flr_clear ? ST_ASSERTED : ST_FLR_HOLDOFF;
      end
      ST_FLR_HOLDOFF: begin
        if (!pg_s || flr_clear) state_n = ST_ASSERTED;
      end
      default: state_n = ST_ASSERTED;
    endcase
  end

  // A request seen while the output is high is remembered until a reset is issued.
  always_comb begin
    if (state_n == ST_ASSERTED) pend_n = 1'b0;
    else                        pend_n = pend_q || (req_s && state_out_high(state_q));
  end

  always_comb begin
    viol_n = viol_q;
    if (!pg_s && ((state_q == ST_MIN_GAP) || (state_q == ST_FLR_HOLDOFF) ||
                  ((state_q == ST_RELEASED) && !flr_clear)))
      viol_n = 1'b1;
  end

  assign gap_start = (state_n == ST_MIN_GAP) && (state_q != ST_MIN_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ASSERTED;
      pend_q  <= 1'b0;
      viol_q  <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      viol_q  <= viol_n;
      out_q   <= state_out_high(state_n);
    end
  end

  assign fund_rst_n    = out_q;
  assign seq_state     = state_q;
  assign req_deferred  = pend_q;
  assign seq_violation = viol_q;

endmodule

// File: rtl/prg_checker.sv
module prg_checker
  import prg_pkg::*;
#(
  parameter int GAP_CYC = 5000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pg_s,
  input logic       clk_ok,
  input logic       flr_busy,
  input logic       flr_settled,
  input logic       fund_rst_n,
  input logic [2:0] seq_state,
  input logic       req_deferred,
  input logic       seq_violation
);

  localparam int HW = $clog2(GAP_CYC + 1);
  logic [HW-1:0] hi_cnt;

  // Length of the current high phase of the output, saturating at the gap.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_cnt <= '0;
    else if (!fund_rst_n)               hi_cnt <= '0;
    else if (int'(hi_cnt) < GAP_CYC)    hi_cnt <= hi_cnt + 1'b1;
  end

  a_r2_release_needs_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fund_rst_n) |-> $past(clk_ok));

  a_r3_no_assert_during_flr: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fund_rst_n) && $past(pg_s)) |-> $past(!flr_busy && flr_settled));

  a_r5_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fund_rst_n) && $past(pg_s)) |-> (int'(hi_cnt) >= GAP_CYC));

  a_r6_holdoff_is_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd4) |-> req_deferred);

  a_r7_pg_loss_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> !fund_rst_n);

  a_r7_violation_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_violation |=> seq_violation);

endmodule

bind pcie_rst_guard prg_checker #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_s(pg_s), .clk_ok(clk_ok),
  .flr_busy(flr_busy), .flr_settled(flr_settled), .fund_rst_n(fund_rst_n),
  .seq_state(seq_state), .req_deferred(req_deferred), .seq_violation(seq_violation));

// File: tb/sim_pcie_rst_guard.sv
`timescale 1ns/1ps
module sim_pcie_rst_guard;

  localparam int NPF = 4, NCK = 4, CPU = 2, GUS = 5, FUS = 7;
  localparam int G = GUS * CPU;   // 10 cycles
  localparam int F = FUS * CPU;   // 14 cycles

  logic clk = 1'b0, rst_n = 1'b0;
  logic pg = 1'b0, req = 1'b0;
  logic [NCK-1:0] ck = '0;
  logic [NPF-1:0] flr = '0;
  logic out, dfr, viol;
  logic [2:0] st;

  always #5 clk = ~clk;

  pcie_rst_guard #(.NUM_PF(NPF), .NUM_CLK(NCK), .CYCLES_PER_US(CPU),
                   .GAP_US(GUS), .FLR_US(FUS)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good_raw(pg), .host_rst_req_raw(req),
    .refclk_ok_raw(ck), .flr_pend_raw(flr), .fund_rst_n(out), .seq_state(st),
    .req_deferred(dfr), .seq_violation(viol));

  int nchk = 0, nerr = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Expected output level for a given state code (R10).
  function automatic bit exp_out_for(input int code);
    return (code == 2) || (code == 3) || (code == 4);
  endfunction

  // Cycles from the FLR input falling to the output falling when a request waits (R4).
  function automatic int exp_flr_fall();
    return F + 3;
  endfunction

  task automatic nstep(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- property monitor (samples 2 ns after each rising edge) --------
  bit pg_h[5];
  bit ck_h[5];
  int run_h[5];
  int hi_run = 0;
  bit out_prev = 0;

  always @(posedge clk) begin
    #2;
    for (int i = 4; i > 0; i--) begin
      pg_h[i] = pg_h[i-1]; ck_h[i] = ck_h[i-1]; run_h[i] = run_h[i-1];
    end
    pg_h[0] = pg; ck_h[0] = &ck; run_h[0] = (|flr) ? 0 : run_h[1] + 1;
    if (mon_on) begin
      chk(out == exp_out_for(int'(st)), "R10 output level matches state", out, exp_out_for(int'(st)));
      if (!pg_h[2]) chk(out == 1'b0, "R7 power-good loss forces reset", out, 0);
      if (out && !out_prev) chk(ck_h[2], "R2 release with all clocks stable", ck_h[2], 1);
      if (!out && out_prev && pg_h[0] && pg_h[1] && pg_h[2] && pg_h[3] && pg_h[4]) begin
        chk(run_h[3] >= F, "R4 FLR quiet before assertion", run_h[3], F);
        chk(hi_run >= G, "R5 minimum high time before assertion", hi_run, G);
      end
    end
    hi_run = out ? hi_run + 1 : 0;
    out_prev = out;
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd7321);

    // R1: reset state
    nstep(5);
    chk(out == 0 && dfr == 0 && viol == 0 && st == 0, "R1 reset outputs", {out, dfr, viol, st}, 0);
    @(negedge clk); rst_n = 1'b1; pg = 1'b1;
    nstep(1);
    chk(out == 0 && st == 0, "R1 right after reset", {out, st}, 0);
    mon_on = 1;
    nstep(10);
    chk(st == 1 && out == 0, "R2 waiting for clocks", st, 1);

    // R2: clocks arrive one by one; release follows the last
    for (int b = 0; b < NCK - 1; b++) begin
      ck[b] = 1'b1; nstep(5);
      chk(out == 0, "R2 held while a clock is not stable", out, 0);
    end
    ck[NCK-1] = 1'b1;
    nstep(2); chk(out == 0, "R2 not released before sync delay", out, 0);
    nstep(1); chk(out == 1 && st == 3, "R2 released 3 cycles after last clock", {out, st}, 5'b1_011);

    // R5: gap length
    nstep(G - 1); chk(st == 3, "R5 still in minimum gap", st, 3);
    nstep(1);     chk(st == 2, "R5 gap over, released", st, 2);

    // R9: host request from released state
    req = 1'b1;
    nstep(3); chk(out == 0 && st == 0 && dfr == 0, "R9 request asserts reset", {out, st, dfr}, 0);
    nstep(5); chk(out == 0, "R9 held while request high", out, 0);
    req = 1'b0;
    nstep(3); chk(st == 1 && out == 0, "R9 waiting for clocks after request", st, 1);
    nstep(1); chk(out == 1 && st == 3, "R9 released again", {out, st}, 5'b1_011);

    // R6: request inside minimum gap is deferred, then applied
    req = 1'b1;
    nstep(3); chk(dfr == 1 && out == 1, "R6 request deferred in gap", {dfr, out}, 3);
    req = 1'b0;
    nstep(G - 4); chk(dfr == 1 && out == 1, "R6 deferral sticky after request drops", {dfr, out}, 3);
    nstep(1); chk(out == 0 && st == 0 && dfr == 0, "R6 applied when gap ends", {out, st, dfr}, 0);
    nstep(1); chk(st == 1, "R6 passes clock wait", st, 1);
    nstep(1); chk(out == 1, "R6 released after deferred pulse", out, 1);

    // R3 / R4: FLR holdoff
    nstep(G);
    chk(st == 2, "R5 released before FLR test", st, 2);
    flr[2] = 1'b1;
    nstep(4);
    req = 1'b1; nstep(4); req = 1'b0;
    nstep(3);
    chk(st == 4 && dfr == 1 && out == 1, "R3 holdoff while FLR pending", {st, dfr, out}, 6'b100_1_1);
    nstep(20);
    chk(out == 1 && st == 4, "R3 still no reset while FLR pending", {out, st}, 5'b1_100);
    flr[2] = 1'b0;
    nstep(exp_flr_fall() - 1); chk(out == 1 && st == 4, "R4 held during settling window", {out, st}, 5'b1_100);
    nstep(1); chk(out == 0 && st == 0 && dfr == 0, "R4 applied after settling window", {out, st, dfr}, 0);
    nstep(2); chk(out == 1 && st == 3, "R4 release after FLR-held reset", {out, st}, 5'b1_011);

    // R7: power-good loss inside gap
    pg = 1'b0;
    nstep(3); chk(out == 0 && viol == 1 && st == 0, "R7 violation on loss in gap", {out, viol, st}, 5'b0_1_000);
    nstep(3); pg = 1'b1;
    nstep(G + 10);
    chk(st == 2 && viol == 1, "R7 violation sticky", {st, viol}, 4'b010_1);

    // R8: clean loss of power-good after settling
    mon_on = 0;
    rst_n = 1'b0; nstep(2);
    chk(out == 0 && st == 0 && viol == 0 && dfr == 0, "R1 second reset clears status", {out, st, viol, dfr}, 0);
    rst_n = 1'b1; nstep(5); mon_on = 1;
    nstep(40);
    chk(st == 2, "R8 released and settled", st, 2);
    pg = 1'b0;
    nstep(3); chk(out == 0 && viol == 0, "R8 no violation on clean loss", {out, viol}, 0);
    pg = 1'b1; nstep(20);

    // Random phase
    for (int it = 0; it < 250; it++) begin
      int kind;
      kind = $urandom_range(0, 9);
      if (kind <= 3) begin
        bit seen;
        pg = 1'b1; ck = '1;
        req = 1'b1; nstep(4); req = 1'b0;
        seen = 0;
        for (int w = 0; w < G + F + 20; w++) begin
          @(negedge clk);
          if (out == 0) begin seen = 1; break; end
        end
        chk(seen, "R6 request eventually applied", seen, 1);
      end else if (kind <= 5) begin
        flr = 4'($urandom_range(1, 15));
        nstep($urandom_range(1, 20));
        flr = '0;
      end else if (kind == 6) begin
        pg = 1'b0; nstep($urandom_range(2, 8)); pg = 1'b1;
      end else if (kind == 7) begin
        int bsel;
        bsel = $urandom_range(0, NCK - 1);
        ck[bsel] = 1'b0; nstep($urandom_range(1, 10)); ck[bsel] = 1'b1;
      end else begin
        nstep($urandom_range(0, 25));
      end
    end
    nstep(60);
    chk(out == 1, "R2 final release with all inputs quiet", out, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule